// File: doc/BRIEF.md
# Latched Status and Interrupt Register Bank

This block holds a small bank of byte-wide status registers for a host. Any bit in a byte can be one of two kinds, fixed when the block is built. Latched bits catch an event pulse and keep it. Real-time bits show the live level of their input and keep no history.

A host clears a latched bit by writing a byte to its status register with a 1 in that bit's position. A mask register sits beside each status register. Latched bits that are not masked pull an active-low interrupt output.

The host sees the status registers first in the register select space and the mask registers after them. One per-bit parameter vector sets which positions are latched and which are real-time.

Top module: `stat_irq_bank`

## Requirements
- R1: A latched bit becomes 1 on the clock edge where its input is high. It stays 1 after the input falls until the host clears it.
- R2: A host write to status register `host_sel` (0..NREG-1) clears the latched bits whose `host_wdata` positions hold 1. Latched bits whose positions hold 0 keep their value.
- R3: A cleared latched bit stays 0 while its input stays low. It is set again only by a new event.
- R4: A real-time bit reads the live level of its input in the same cycle. Host writes never change what it reads.
- R5: If an event and a host clear hit the same latched bit on the same edge, the bit stays 1.
- R6: `irq_n` is 0 exactly when some latched bit is 1 and its mask bit is 1, where mask bit 1 means enabled. Real-time bits never drive `irq_n`.
- R7: A write to mask register `host_sel` = NREG+r changes `irq_n` from the clock edge that takes the write onwards. It leaves the latched bits unchanged.
- R8: After reset, all latched bits and all mask bits read 0, and `irq_n` is 1.
- R9: A mask register reads back the byte last written to it. Selects 0..NREG-1 read status and NREG..2*NREG-1 read masks. Writing a mask register does not change any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_i | input | NREG*W | Event pulses (latched positions) and live conditions (real-time positions), register r in bits r*W+W-1..r*W |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | SELW | Register select: status registers then mask registers |
| host_wdata | input | W | Host write data |
| host_rdata | output | W | Read data of the selected register |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The collision that matters is an event on a latched bit in the same cycle as a host write that clears that bit. The random stimulus raises events often and sends write-one bytes to the status registers, so these collisions occur many times. A directed step forces one onto a bit that is not yet set, so the bit can only end up 1 if the event takes priority. The expected value comes from a bench model in which the event beats the clear. A second overlap also gets a directed check: a mask write in the same cycle as an event, judged by `irq_n` in the cycle after.

// File: rtl/stat_irq_bank.sv
module stat_irq_bank #(
  parameter int NREG = 2,
  parameter int W = 8,
  parameter logic [NREG*W-1:0] LATCHED = 16'hC3F5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NREG*W-1:0]             sig_i,
  input  logic                          host_wr,
  input  logic [$clog2(2*NREG)-1:0]     host_sel,
  input  logic [W-1:0]                  host_wdata,
  output logic [W-1:0]                  host_rdata,
  output logic                          irq_n
);
  localparam int N = NREG * W;

  logic [N-1:0] lat, en, clr, view;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    assign clr[r*W +: W] = (host_wr && int'(host_sel) == r)
                           ? (host_wdata & LATCHED[r*W +: W]) : '0;

    always_ff @(posedge clk) begin
      if (!rst_n)
        en[r*W +: W] <= '0;
      else if (host_wr && int'(host_sel) == NREG + r)
        en[r*W +: W] <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lat <= '0;
    else        lat <= (lat & ~clr) | (sig_i & LATCHED);
  end

  assign view = lat | (sig_i & ~LATCHED);

  always_comb begin
    host_rdata = '0;
    for (int r = 0; r < NREG; r++) begin
      if (int'(host_sel) == r)        host_rdata = view[r*W +: W];
      if (int'(host_sel) == NREG + r) host_rdata = en[r*W +: W];
    end
  end

  assign irq_n = ~|(lat & en);
endmodule

module stat_irq_bank_chk #(
  parameter int NREG = 2,
  parameter int W = 8,
  parameter logic [NREG*W-1:0] LATCHED = 16'hC3F5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NREG*W-1:0]         sig_i,
  input logic                      host_wr,
  input logic [$clog2(2*NREG)-1:0] host_sel,
  input logic [W-1:0]              host_wdata,
  input logic                      irq_n,
  input logic [NREG*W-1:0]         lat,
  input logic [NREG*W-1:0]         en
);
  logic [NREG*W-1:0] wclr;
  logic mwr, armed;

  always_comb begin
    wclr = '0;
    mwr = 1'b0;
    for (int r = 0; r < NREG; r++) begin
      if (host_wr && int'(host_sel) == r) wclr[r*W +: W] = host_wdata;
      if (host_wr && int'(host_sel) == NREG + r) mwr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((lat & $past(sig_i & LATCHED)) == $past(sig_i & LATCHED))); // R1 R5
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((lat & ~$past(lat) & ~$past(sig_i)) == '0)); // R3
  AST_CLR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (($past(lat) & ~lat & ~$past(wclr)) == '0)); // R2
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> irq_n); // R6
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(mwr)) |-> $stable(en)); // R7
endmodule

bind stat_irq_bank stat_irq_bank_chk #(.NREG(NREG), .W(W), .LATCHED(LATCHED)) u_chk (.*);

// File: tb/tb_stat_irq_bank.sv
module tb_stat_irq_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 2;
  localparam int W = 8;
  localparam int N = NREG * W;
  localparam logic [N-1:0] LAT = 16'hC3F5;

  logic clk = 1'b0, rst_n = 1'b0, host_wr = 1'b0, irq_n;
  logic [N-1:0] sig_i = '0;
  logic [1:0] host_sel = '0;
  logic [W-1:0] host_wdata = '0, host_rdata;

  logic [N-1:0] m_lat = '0, m_en = '0;
  int checks = 0, fails = 0, cycles = 0;

  stat_irq_bank #(.NREG(NREG), .W(W), .LATCHED(LAT)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] exp_read(input logic [1:0] sel, input logic [N-1:0] s);
    logic [N-1:0] v = m_lat | (s & ~LAT);
    if (int'(sel) < NREG) return v[int'(sel)*W +: W];
    return m_en[(int'(sel)-NREG)*W +: W];
  endfunction

  function automatic logic exp_irq_n();
    return ~|(m_lat & m_en);
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] s, input logic wr, input logic [1:0] sel,
                      input logic [W-1:0] wd, input string tag);
    @(negedge clk);
    sig_i = s; host_wr = wr; host_sel = sel; host_wdata = wd;
    #1;
    check({tag, " read"}, host_rdata, exp_read(sel, s));
    check("R6 irq_n", {7'd0, irq_n}, {7'd0, exp_irq_n()});
    @(posedge clk);
    if (rst_n) begin
      logic [N-1:0] c = '0;
      if (wr && int'(sel) < NREG) c[int'(sel)*W +: W] = wd;
      m_lat = (m_lat & ~(c & LAT)) | (s & LAT);
      if (wr && int'(sel) >= NREG) m_en[(int'(sel)-NREG)*W +: W] = wd;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected <100000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd17));
    repeat (3) @(posedge clk);
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); host_sel = 2'(s); #1;
      check("R8 reset read", host_rdata, 8'h00);
    end
    check("R8 reset irq_n", {7'd0, irq_n}, 8'h01);
    @(negedge clk); rst_n = 1'b1;

    step(16'h0001, 0, 0, 0, "R1");
    step(16'h0000, 0, 0, 0, "R1 held");
    step(16'h0000, 1, 2, 8'h01, "R7");
    step(16'h0000, 0, 0, 0, "R7 irq and bit kept");
    check("R7 irq low", {7'd0, irq_n}, 8'h00);
    step(16'h0000, 1, 0, 8'hFE, "R2 zero keeps");
    step(16'h0000, 1, 0, 8'h01, "R2 clear");
    step(16'h0000, 0, 0, 0, "R2 cleared");
    check("R2 irq released", {7'd0, irq_n}, 8'h01);
    step(16'h0000, 0, 0, 0, "R3 stays clear");
    step(16'h0004, 1, 0, 8'h04, "R5 collide");
    step(16'h0000, 0, 0, 0, "R5 event wins");
    check("R5 bit kept", host_rdata, 8'h05 & 8'h04);
    step(16'h0002, 1, 2, 8'h02, "R4 live");
    step(16'h0002, 1, 0, 8'h02, "R4 write ignored");
    step(16'h0002, 0, 0, 0, "R4 still live");
    check("R6 realtime no irq", {7'd0, irq_n}, 8'h01);
    step(16'h0000, 0, 0, 0, "R4 drops");
    step(16'h0100, 1, 3, 8'h01, "R9 mask write with event");
    step(16'h0000, 0, 3, 0, "R9 mask readback");
    check("R7 irq after mask and event", {7'd0, irq_n}, 8'h00);
    step(16'h0000, 0, 1, 0, "R9 status untouched");

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] sel = 2'($urandom_range(0, 3));
      step(N'($urandom & $urandom & $urandom), 1'($urandom), sel, W'($urandom),
           (int'(sel) < NREG) ? "R2 random status" : "R9 random mask");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule